// File: doc/BRIEF.md
# Two-Level Masked Interrupt Pending Controller

This block gathers 32 interrupt sources and presents them to a processor on two lines: a normal request (`irq`) and a fast request (`fiq`). Each source input is edge-detected and latched into a source-pending register. A mask register blocks selected sources. A one-hot mode register can divert one source to the fast line. The remaining pending, unmasked sources are arbitrated by fixed priority, with the lowest index winning. The winner is recorded alone in an interrupt-pending register, which drives `irq`.

Software reaches the block over a plain synchronous register bus. Both pending registers are cleared by writing ones. An acknowledge therefore clears the source-pending bit first and then the interrupt-pending bit. For level-style sources, software sets the mask bit before these two writes.

A two-state arbiter controls when a new winner is taken:
- **ARB_IDLE**: interrupt-pending is empty. On the transition *grant*, some candidate exists; its lowest-index bit is loaded and the arbiter moves to ARB_HELD.
- **ARB_HELD**: one bit is held. On the transition *release*, a write clears that bit and the arbiter returns to ARB_IDLE.

Sources that arrive while a bit is held wait their turn.

Top module: `irq_pend_ctrl`

## Requirements
- R1: After reset, source-pending, mode and interrupt-pending read 0, mask reads 0xFFFFFFFF, and `irq` and `fiq` are low.
- R2: A 0-to-1 transition on a source input sets its source-pending bit one clock later, even when that source is masked. A source held high does not set the bit again after it is cleared.
- R3: Writing to source-pending (offset 0x00) clears every bit written as 1; bits written as 0 are unchanged.
- R4: Mask (offset 0x08): bit n = 1 keeps source n out of arbitration. Clearing the bit lets an already pending source win on the next clock.
- R5: Among pending sources that are unmasked and not fast, the lowest index wins. Interrupt-pending holds at most that one bit, and a winner is loaded only while interrupt-pending is empty (ARB_IDLE), one clock after the candidate appears.
- R6: Writing to interrupt-pending (offset 0x10) clears every bit written as 1; zero bits have no effect. Writing back a value just read from it clears it, and the next winner loads one clock after the clear.
- R7: `irq` is high exactly while interrupt-pending is nonzero.
- R8: Mode (offset 0x04) bit n = 1 routes source n to `fiq`. `fiq` is high while that source is pending and unmasked, and the source is then never loaded into interrupt-pending. Writing 0 to mode returns the source to normal arbitration.
- R9: A mode write with more than one bit set is ignored, so the mode register always holds zero or one set bit.
- R10: Source indices 6 and 24 are reserved: they never become pending and always read 0.
- R11: Offsets other than 0x00, 0x04, 0x08 and 0x10 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 5 | Register byte offset |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| src_in | input | 32 | Interrupt source inputs, one per index |
| irq | output | 1 | Normal interrupt request |
| fiq | output | 1 | Fast interrupt request |

## Verification
The hardest situation to reach is ARB_HELD while other candidates keep arriving, followed by the one idle clock after a release, when the next winner is chosen. The stimulus first latches two sources together to load a winner. It then raises a lower-index source while the winner is held, to show that the held bit does not change. The held bit is then released with the startup-style read-and-write-back, and the expected winner is sampled exactly one clock later.

A second difficult case is a source that is pending while it is routed to the fast line. The bench latches that source with its mode bit set, confirms that only `fiq` responds, and then clears the mode. This shows the same pending bit entering normal arbitration.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
    typedef enum logic [0:0] {
        ARB_IDLE = 1'b0,
        ARB_HELD = 1'b1
    } arb_state_t;

    localparam int unsigned OFS_SRCP = 32'h00;
    localparam int unsigned OFS_MODE = 32'h04;
    localparam int unsigned OFS_MASK = 32'h08;
    localparam int unsigned OFS_INTP = 32'h10;
endpackage

// File: rtl/ipc_edge_latch.sv
module ipc_edge_latch #(
    parameter int NSRC = 32,
    parameter logic [NSRC-1:0] RSVD_MAP = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_in,
    input  logic [NSRC-1:0] clr,
    output logic [NSRC-1:0] pend,
    output logic [NSRC-1:0] rise
);
    logic [NSRC-1:0] src_q;

    // Rising edges of usable sources only.
    assign rise = src_in & ~src_q & ~RSVD_MAP;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0;
            pend  <= '0;
        end else begin
            src_q <= src_in;
            // A new edge wins over a clear arriving in the same cycle.
            pend  <= ((pend & ~clr) | rise) & ~RSVD_MAP;
        end
    end
endmodule

// File: rtl/ipc_cfg_regs.sv
module ipc_cfg_regs #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_mask,
    input  logic            wr_mode,
    input  logic [NSRC-1:0] wdata,
    output logic [NSRC-1:0] mask,
    output logic [NSRC-1:0] mode
);
    logic mode_ok;

    // Zero or exactly one bit set.
    assign mode_ok = (wdata & (wdata - 1'b1)) == '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask <= '1;
            mode <= '0;
        end else begin
            if (wr_mask) mask <= wdata;
            if (wr_mode && mode_ok) mode <= wdata;
        end
    end
endmodule

// File: rtl/ipc_arbiter.sv
module ipc_arbiter
    import ipc_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] cand,
    input  logic [NSRC-1:0] clr,
    output logic [NSRC-1:0] intpnd,
    output arb_state_t      state
);
    arb_state_t      state_nx;
    logic [NSRC-1:0] lowest;

    // Isolate the lowest set bit.
    assign lowest = cand & (~cand + 1'b1);

    always_comb begin
        state_nx = state;
        unique case (state)
            ARB_IDLE: if (cand != '0)           state_nx = ARB_HELD; // grant
            ARB_HELD: if ((intpnd & clr) != '0) state_nx = ARB_IDLE; // release
            default:                            state_nx = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ARB_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            intpnd <= '0;
        end else begin
            unique case (state)
                ARB_IDLE: if (cand != '0) intpnd <= lowest;
                ARB_HELD: intpnd <= intpnd & ~clr;
                default:  intpnd <= '0;
            endcase
        end
    end
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
    import ipc_pkg::*;
#(
    parameter int NSRC = 32,
    parameter int ADDR_W = 5,
    parameter logic [NSRC-1:0] RSVD_MAP = 32'h0100_0040
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [NSRC-1:0]   wr_data,
    output logic [NSRC-1:0]   rd_data,
    input  logic [NSRC-1:0]   src_in,
    output logic              irq,
    output logic              fiq
);
    logic            sel_srcp, sel_mode, sel_mask, sel_intp;
    logic [NSRC-1:0] clr_src, clr_int;
    logic [NSRC-1:0] srcpnd, rise, mask, mode, intpnd, cand;
    arb_state_t      arb_state;

    assign sel_srcp = addr == ADDR_W'(OFS_SRCP);
    assign sel_mode = addr == ADDR_W'(OFS_MODE);
    assign sel_mask = addr == ADDR_W'(OFS_MASK);
    assign sel_intp = addr == ADDR_W'(OFS_INTP);

    assign clr_src = (wr_en && sel_srcp) ? wr_data : '0;
    assign clr_int = (wr_en && sel_intp) ? wr_data : '0;

    ipc_edge_latch #(.NSRC(NSRC), .RSVD_MAP(RSVD_MAP)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .src_in(src_in),
        .clr   (clr_src),
        .pend  (srcpnd),
        .rise  (rise)
    );

    ipc_cfg_regs #(.NSRC(NSRC)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_mask(wr_en && sel_mask),
        .wr_mode(wr_en && sel_mode),
        .wdata  (wr_data),
        .mask   (mask),
        .mode   (mode)
    );

    assign cand = srcpnd & ~mask & ~mode;

    ipc_arbiter #(.NSRC(NSRC)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .cand  (cand),
        .clr   (clr_int),
        .intpnd(intpnd),
        .state (arb_state)
    );

    assign irq = intpnd != '0;
    assign fiq = (srcpnd & mode & ~mask) != '0;

    always_comb begin
        rd_data = '0;
        if (sel_srcp)      rd_data = srcpnd;
        else if (sel_mode) rd_data = mode;
        else if (sel_mask) rd_data = mask;
        else if (sel_intp) rd_data = intpnd;
    end
endmodule

// File: rtl/irq_pend_ctrl_chk.sv
module irq_pend_ctrl_chk
    import ipc_pkg::*;
#(
    parameter int NSRC = 32,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [NSRC-1:0]   wr_data,
    input logic              irq,
    input logic [NSRC-1:0]   srcpnd,
    input logic [NSRC-1:0]   rise,
    input logic [NSRC-1:0]   mask,
    input logic [NSRC-1:0]   mode,
    input logic [NSRC-1:0]   intpnd,
    input arb_state_t        state
);
    logic [NSRC-1:0] elig;
    logic            int_clr_hit;

    assign elig        = srcpnd & ~mask & ~mode;
    assign int_clr_hit = wr_en && (addr == ADDR_W'(OFS_INTP)) && ((wr_data & intpnd) != '0);

    AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((srcpnd & $past(rise)) == $past(rise))); // R2

    AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (($past(elig) & intpnd) != '0)); // R4

    AST_INTPND_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(intpnd)); // R5

    AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ARB_IDLE) |-> (intpnd == '0)); // R5

    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ARB_HELD && !int_clr_hit) |=> $stable(intpnd)); // R6

    AST_MODE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mode)); // R9
endmodule

bind irq_pend_ctrl irq_pend_ctrl_chk #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (addr),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .irq    (irq),
    .srcpnd (srcpnd),
    .rise   (rise),
    .mask   (mask),
    .mode   (mode),
    .intpnd (intpnd),
    .state  (arb_state)
);

// File: tb/tb_irq_pend_ctrl.sv
module tb_irq_pend_ctrl;
    localparam logic [4:0] A_SRCP = 5'h00;
    localparam logic [4:0] A_MODE = 5'h04;
    localparam logic [4:0] A_MASK = 5'h08;
    localparam logic [4:0] A_HOLE = 5'h0C;
    localparam logic [4:0] A_INTP = 5'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [31:0] src_in = '0;
    logic        irq, fiq;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_pend_ctrl dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .src_in(src_in), .irq(irq), .fiq(fiq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic pulse(input logic [31:0] bits);
        @(negedge clk);
        src_in = src_in | bits;
        @(negedge clk);
        src_in = src_in & ~bits;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_SRCP, v); chk("R1 srcpnd", v, 32'h0);
        rd(A_MODE, v); chk("R1 mode", v, 32'h0);
        rd(A_MASK, v); chk("R1 mask", v, 32'hFFFF_FFFF);
        rd(A_INTP, v); chk("R1 intpnd", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 fiq", {31'b0, fiq}, 32'h0);
    endtask

    task automatic t_latch_and_mask();
        logic [31:0] v;
        pulse(32'h8);
        @(negedge clk);
        rd(A_SRCP, v); chk("R2 masked edge latches", v, 32'h8);
        rd(A_INTP, v); chk("R4 masked source blocked", v, 32'h0);
        chk("R7 irq low while empty", {31'b0, irq}, 32'h0);
        @(negedge clk); src_in[5] = 1'b1;          // held high
        @(negedge clk);
        wr(A_SRCP, 32'h20);
        @(negedge clk);
        rd(A_SRCP, v); chk("R2 steady high no re-set", v, 32'h8);
        src_in[5] = 1'b0;
        wr(A_MASK, ~32'h8);
        @(negedge clk);
        rd(A_INTP, v); chk("R4 unmask lets through", v, 32'h8);
        chk("R7 irq high", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr(A_SRCP, 32'h0);
        rd(A_SRCP, v); chk("R3 zero write no effect", v, 32'h8);
        wr(A_INTP, 32'h0);
        rd(A_INTP, v); chk("R6 zero write no effect", v, 32'h8);
        wr(A_SRCP, 32'h8);
        rd(A_SRCP, v); chk("R3 one clears", v, 32'h0);
        rd(A_INTP, v); chk("R6 intpnd kept after srcpnd clear", v, 32'h8);
        wr(A_INTP, 32'h8);
        rd(A_INTP, v); chk("R6 one clears", v, 32'h0);
        chk("R7 irq drops", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_priority();
        logic [31:0] v;
        wr(A_MASK, 32'h0);
        pulse(32'h204);
        @(negedge clk);
        rd(A_INTP, v); chk("R5 lowest wins", v, 32'h4);
        pulse(32'h2);
        @(negedge clk);
        rd(A_INTP, v); chk("R5 held bit unchanged", v, 32'h4);
        rd(A_SRCP, v); chk("R2 more pending", v, 32'h206);
        wr(A_SRCP, 32'h4);
        rd(A_INTP, v);
        wr(A_INTP, v);                             // write-back
        rd(A_INTP, v); chk("R6 write-back clears", v, 32'h0);
        @(negedge clk);
        rd(A_INTP, v); chk("R6 next winner", v, 32'h2);
        wr(A_SRCP, 32'h2);
        wr(A_INTP, 32'h2);
        @(negedge clk);
        rd(A_INTP, v); chk("R5 last winner", v, 32'h200);
        wr(A_SRCP, 32'h200);
        wr(A_INTP, 32'h200);
        @(negedge clk);
        rd(A_INTP, v); chk("R6 all drained", v, 32'h0);
    endtask

    task automatic t_fast();
        logic [31:0] v;
        wr(A_MODE, 32'h10);
        rd(A_MODE, v); chk("R8 mode set", v, 32'h10);
        pulse(32'h10);
        #1;
        chk("R8 fiq high", {31'b0, fiq}, 32'h1);
        @(negedge clk);
        @(negedge clk);
        rd(A_INTP, v); chk("R8 fast not arbitrated", v, 32'h0);
        chk("R8 irq low", {31'b0, irq}, 32'h0);
        wr(A_MASK, 32'h10);
        chk("R8 masked fiq low", {31'b0, fiq}, 32'h0);
        wr(A_MASK, 32'h0);
        chk("R8 unmasked fiq high", {31'b0, fiq}, 32'h1);
        wr(A_MODE, 32'h3);
        rd(A_MODE, v); chk("R9 multi-bit ignored", v, 32'h10);
        wr(A_MODE, 32'h0);
        chk("R8 routing off fiq low", {31'b0, fiq}, 32'h0);
        @(negedge clk);
        rd(A_INTP, v); chk("R8 back to normal", v, 32'h10);
        wr(A_SRCP, 32'h10);
        wr(A_INTP, 32'h10);
    endtask

    task automatic t_reserved();
        logic [31:0] v;
        pulse(32'h0100_0040);
        @(negedge clk);
        rd(A_SRCP, v); chk("R10 reserved never pend", v, 32'h0);
        chk("R10 no irq", {31'b0, irq}, 32'h0);
        pulse(32'hFFFF_FFFF);
        rd(A_SRCP, v); chk("R10 reserved read zero", v, 32'hFEFF_FFBF);
        wr(A_SRCP, 32'hFFFF_FFFF);
        wr(A_INTP, 32'hFFFF_FFFF);
        @(negedge clk);
        rd(A_INTP, v); chk("R6 cleared after flood", v, 32'h0);
    endtask

    task automatic t_hole();
        logic [31:0] v;
        rd(A_HOLE, v); chk("R11 hole reads zero", v, 32'h0);
        wr(A_HOLE, 32'hFFFF_FFFF);
        rd(A_MASK, v); chk("R11 mask untouched", v, 32'h0);
        rd(A_MODE, v); chk("R11 mode untouched", v, 32'h0);
        rd(A_SRCP, v); chk("R11 srcpnd untouched", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latch_and_mask();
        t_w1c();
        t_priority();
        t_fast();
        t_reserved();
        t_hole();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule